// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block is a free-running up-counter paired with a compare register, in the style of a processor's built-in timer. Each asserted tick enable stands for one counter period, for example 10 ns at a nominal 100 MHz timer rate. On each such tick the counter steps by one and wraps at 2^CNT_W. Software loads either register through a single write port and reads the live count back. When the counter arrives at the compare value, a timer-pending flag sets. The flag stays set until the compare register is written again.

A freeze input stops the counter and blocks match detection. A run-time routing field chooses which one of the interrupt output lines carries the pending flag. The block does not generate the timer clock and does not hold the rest of the interrupt cause and status state.

Top module: `interval_timer`

## Requirements
- R1: When `tick_en` is high, `freeze` is low and no count write is made, `rd_count` is one higher after the clock edge. When `tick_en` is low, `rd_count` does not change. `rd_count` always shows the live counter register.
- R2: The counter wraps modulo 2^CNT_W, so all ones steps to zero.
- R3: While `freeze` is high, the counter holds its value even when `tick_en` is high.
- R4: A write with `wr_sel` = 0 targets the counter, and a write with `wr_sel` = 1 targets the compare register. A counter write loads `wr_data` whether `freeze` is high or low, and it takes priority over a tick in the same cycle.
- R5: In a cycle where the counter equals the compare value, `freeze` is low, and the two were unequal in the previous cycle, `pending` is set at the next edge.
- R6: Equality is detected only once, in the first cycle it holds. If equality starts or continues while `freeze` is high, it does not set `pending` then. It also does not set `pending` after `freeze` falls, as long as the values stay equal.
- R7: A compare write clears `pending` at the next edge. The clear wins over a match detected in the same cycle. Once set, `pending` stays set until a compare write. If a compare write makes the compare value equal to an unchanged count that differed from the old compare value, this counts as a new match.
- R8: `irq_lines` has only bit `route_sel` high while `pending` is high, and is all zeros otherwise. A change of `route_sel` moves the line in the same cycle.
- R9: After reset, the count is 0, the compare value is all ones, `pending` is 0 and counting is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One counter period has elapsed |
| freeze | input | 1 | Stop counting and match detection |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 compare |
| wr_data | input | CNT_W | Write value |
| route_sel | input | SEL_W | Index of the interrupt line to drive |
| rd_count | output | CNT_W | Live counter value |
| pending | output | 1 | Timer-pending flag |
| irq_lines | output | LINES | Routed timer interrupt |

## Verification
The hardest situation to reach from the ports is equality that already holds when counting resumes. The bench builds it by writing the counter to the compare value while `freeze` is high, then releasing `freeze`, and it expects `pending` to stay low. A second hard case is a compare write that lands in the same cycle as a fresh match; the bench places that write exactly one cycle after the tick that makes the values equal. The bench is elaborated with an 8-bit counter so that the reset compare value and the wrap are reachable in a few hundred ticks. It sweeps compare values over the whole range and every routing index.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  typedef enum logic {
    TGT_COUNT   = 1'b0,
    TGT_COMPARE = 1'b1
  } wr_tgt_e;
endpackage

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             freeze,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_q,
  output logic             advance
);
  function automatic logic [CNT_W-1:0] cnt_next(
    input logic [CNT_W-1:0] cur,
    input logic             ld,
    input logic [CNT_W-1:0] ldv,
    input logic             step
  );
    if (ld)        return ldv;
    else if (step) return cur + CNT_W'(1);
    else           return cur;
  endfunction

  assign advance = tick_en && !freeze && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= cnt_next(count_q, load, load_val, advance);
  end
endmodule

// File: rtl/itmr_match.sv
module itmr_match #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             eq_now,
  output logic             match_evt,
  output logic             pending
);
  localparam logic [CNT_W-1:0] CMP_RST = {CNT_W{1'b1}};

  logic eq_q;

  function automatic logic pend_next(
    input logic cur,
    input logic clr,
    input logic set
  );
    if (clr)      return 1'b0;
    else if (set) return 1'b1;
    else          return cur;
  endfunction

  assign eq_now    = (count_q == cmp_q);
  assign match_evt = eq_now && !eq_q && !freeze;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= CMP_RST;
      eq_q    <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (cmp_wr) cmp_q <= cmp_val;
      eq_q    <= eq_now;
      pending <= pend_next(pending, cmp_wr, match_evt);
    end
  end
endmodule

// File: rtl/itmr_route.sv
module itmr_route #(
  parameter int LINES = 8,
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             active,
  output logic [LINES-1:0] lines
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = active && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W = 32,
  parameter int LINES = 8,
  localparam int SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             freeze,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [SEL_W-1:0] route_sel,
  output logic [CNT_W-1:0] rd_count,
  output logic             pending,
  output logic [LINES-1:0] irq_lines
);
  import itmr_pkg::*;

  logic             cnt_wr;
  logic             cmp_wr;
  logic             advance;
  logic             eq_now;
  logic             match_evt;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] cmp_q;

  assign cnt_wr = wr_en && (wr_tgt_e'(wr_sel) == TGT_COUNT);
  assign cmp_wr = wr_en && (wr_tgt_e'(wr_sel) == TGT_COMPARE);

  itmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .freeze   (freeze),
    .load     (cnt_wr),
    .load_val (wr_data),
    .count_q  (count_q),
    .advance  (advance)
  );

  itmr_match #(.CNT_W(CNT_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (freeze),
    .cmp_wr    (cmp_wr),
    .cmp_val   (wr_data),
    .count_q   (count_q),
    .cmp_q     (cmp_q),
    .eq_now    (eq_now),
    .match_evt (match_evt),
    .pending   (pending)
  );

  itmr_route #(.LINES(LINES), .SEL_W(SEL_W)) u_route (
    .sel    (route_sel),
    .active (pending),
    .lines  (irq_lines)
  );

  assign rd_count = count_q;
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
  parameter int CNT_W = 32,
  parameter int LINES = 8,
  localparam int SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             freeze,
  input logic             cnt_wr,
  input logic             cmp_wr,
  input logic             match_evt,
  input logic [CNT_W-1:0] wr_data,
  input logic [SEL_W-1:0] route_sel,
  input logic [CNT_W-1:0] rd_count,
  input logic             pending,
  input logic [LINES-1:0] irq_lines
);
  a_r1_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !freeze && !cnt_wr) |=> rd_count == $past(rd_count) + CNT_W'(1));

  a_r3_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cnt_wr) |=> rd_count == $past(rd_count));

  a_r4_count_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> rd_count == $past(wr_data));

  a_r5_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !cmp_wr) |=> pending);

  a_r6_no_match_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !match_evt);

  a_r7_cmp_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !pending);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !cmp_wr) |=> pending);

  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines) && ((irq_lines != '0) == pending));

  a_r8_selected: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> $countones(irq_lines >> route_sel) == 1 && irq_lines[route_sel]);
endmodule

bind interval_timer itmr_checker #(.CNT_W(CNT_W), .LINES(LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .freeze    (freeze),
  .cnt_wr    (cnt_wr),
  .cmp_wr    (cmp_wr),
  .match_evt (match_evt),
  .wr_data   (wr_data),
  .route_sel (route_sel),
  .rd_count  (rd_count),
  .pending   (pending),
  .irq_lines (irq_lines)
);

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
  localparam int W     = 8;
  localparam int L     = 8;
  localparam int SW    = 3;
  localparam int CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          frz = 1'b0;
  logic          wen = 1'b0;
  logic          wsel = 1'b0;
  logic [W-1:0]  wdata = '0;
  logic [SW-1:0] sel = '0;
  logic [W-1:0]  rd_count;
  logic          pending;
  logic [L-1:0]  irq_lines;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [W-1:0] m_cnt = '0;
  logic [W-1:0] m_cmp = '1;
  logic         m_pend = 1'b0;
  logic         m_eq = 1'b0;

  interval_timer #(.CNT_W(W), .LINES(L)) u_interval_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick),
    .freeze    (frz),
    .wr_en     (wen),
    .wr_sel    (wsel),
    .wr_data   (wdata),
    .route_sel (sel),
    .rd_count  (rd_count),
    .pending   (pending),
    .irq_lines (irq_lines)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock edge; the reference state advances from the requirements
  task automatic cyc();
    logic         cw, mw, hit, eqn;
    logic [W-1:0] nc;
    cw  = wen && !wsel;
    mw  = wen && wsel;
    eqn = (m_cnt == m_cmp);
    hit = eqn && !m_eq && !frz;
    nc  = cw ? wdata : ((tick && !frz) ? W'(m_cnt + 1) : m_cnt);
    @(posedge clk);
    #1;
    if (mw) m_cmp = wdata;
    m_pend = mw ? 1'b0 : (hit ? 1'b1 : m_pend);
    m_eq   = eqn;
    m_cnt  = nc;
  endtask

  task automatic model_check(input string tag);
    check({tag, " count"}, 32'(rd_count), 32'(m_cnt));
    check({tag, " pending"}, 32'(pending), 32'(m_pend));
    check({tag, " lines"}, 32'(irq_lines), 32'(m_pend ? (L'(1) << sel) : L'(0)));
  endtask

  task automatic write(input logic tgt, input logic [W-1:0] v);
    wen = 1'b1; wsel = tgt; wdata = v;
    cyc();
    wen = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state
    check("R9 count", 32'(rd_count), 0);
    check("R9 pending", 32'(pending), 0);
    check("R9 lines", 32'(irq_lines), 0);

    // R1 ticking and idle
    tick = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      cyc();
      check("R1 step", 32'(rd_count), 32'(i));
    end
    tick = 1'b0;
    for (int i = 0; i < 5; i++) begin
      cyc();
      check("R1 idle", 32'(rd_count), 20);
    end

    // R9 reset compare is all ones: count up to it
    write(1'b0, W'(250));
    tick = 1'b1;
    repeat (5) cyc();
    tick = 1'b0;
    check("R9 at top", 32'(rd_count), 255);
    check("R9 not yet", 32'(pending), 0);
    cyc();
    check("R9 compare all ones", 32'(pending), 1);
    model_check("R9");

    // R7 compare write clears
    write(1'b1, W'(8'h10));
    check("R7 clear", 32'(pending), 0);

    // R2 wrap
    tick = 1'b1;
    cyc();
    tick = 1'b0;
    check("R2 wrap", 32'(rd_count), 0);

    // R5 / R8 sweep over compare values and routes
    for (int c = 0; c < 256; c += 15) begin
      write(1'b0, W'(c - 3));
      write(1'b1, W'(c));
      check("R7 after cmp write", 32'(pending), 0);
      tick = 1'b1;
      for (int k = 0; k < 3; k++) begin
        cyc();
        check("R5 before match", 32'(pending), 0);
      end
      tick = 1'b0;
      cyc();
      check("R5 match", 32'(pending), 1);
      for (int s = 0; s < L; s++) begin
        sel = SW'(s);
        #1;
        check("R8 route", 32'(irq_lines), 32'(L'(1) << s));
      end
      cyc();
      check("R7 sticky", 32'(pending), 1);
      model_check("R5 model");
    end

    // R3 / R4 / R6 freeze behaviour
    write(1'b1, W'(8'h40));
    write(1'b0, W'(8'h3E));
    frz = 1'b1; tick = 1'b1;
    for (int i = 0; i < 10; i++) begin
      cyc();
      check("R3 frozen", 32'(rd_count), 32'h3E);
    end
    write(1'b0, W'(8'h40));
    check("R4 load frozen", 32'(rd_count), 32'h40);
    repeat (3) begin
      cyc();
      check("R6 frozen equal", 32'(pending), 0);
    end
    frz = 1'b0; tick = 1'b0;
    repeat (3) begin
      cyc();
      check("R6 no redetect", 32'(pending), 0);
      check("R8 idle lines", 32'(irq_lines), 0);
    end

    // R4 write beats tick
    tick = 1'b1;
    write(1'b0, W'(8'h80));
    check("R4 priority", 32'(rd_count), 32'h80);
    cyc();
    tick = 1'b0;
    check("R1 after load", 32'(rd_count), 32'h81);

    // R7 compare written equal to the count is a new match
    write(1'b1, W'(8'h81));
    check("R7 eq write clear", 32'(pending), 0);
    cyc();
    check("R7 eq write match", 32'(pending), 1);

    // R7 clear wins over a same-cycle match
    write(1'b0, W'(8'h90));
    write(1'b1, W'(8'h91));
    tick = 1'b1;
    cyc();
    tick = 1'b0;
    write(1'b1, W'(8'h91));
    check("R7 clear wins", 32'(pending), 0);
    repeat (2) begin
      cyc();
      check("R7 stays clear", 32'(pending), 0);
    end
    model_check("R7 model");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule